// File: doc/BRIEF.md
# Macroblock Field Decoder

This block sits right after a source coder that sends one byte at a time. Each byte comes with a 4-bit type tag and a strobe. The block takes tag and byte when it sees the strobe rise. It decodes the byte according to its tag and emits one typed record for each transfer, toward a variable-length coder further down the chain. Each record carries a kind code, which is the tag itself, and an 8-bit value.

Absolute quantities are turned into the relative form that the compressed bitstream needs. The macroblock number becomes an address increment measured against the last macroblock sent in the same group. Each motion-vector component becomes a difference from the vector of the previous macroblock, and that difference is wrapped into five bits. The predictor is cleared at each row start, after a gap in addresses, and after a macroblock that was not motion compensated. Control and coded-block-pattern bytes leave with their unused bits cleared. Run bytes keep their end-of-sub-block marker.

The record leaves two system clocks after the first clock edge that sees the strobe high.

Top module: `mb_field_decoder`

## Requirements
- R1: While reset is held and after it is released with no strobe, `rec_valid_o` is 0.
- R2: The strobe may stay high for any number of clocks. Each rising strobe gives exactly one record. The record is valid for one clock, in the second clock after the first edge that sampled the strobe high. `rec_kind_o` equals the tag of that transfer.
- R3: Tags 1010 to 1110 and tag 1111 (wait) produce no record, even when they come with a strobe.
- R4: For tag 0010 (control), the value is the byte with bits 7 and 4 cleared. Bit 3 of this byte is the motion-compensated flag used by R10 and R11.
- R5: For tag 0110 (coded block pattern), the value is the byte with bits 7 and 0 cleared.
- R6: The value is zero-extended from a field in the low bits of the byte. The field is 4 bits for tag 0000 (group), 5 bits for tag 0011 (quantiser) and 3 bits for tag 0111 (sub-block).
- R7: For tag 1000 (zero run), the value holds bits 5:0 of the byte. Bits 7:6 pass through as 11 when both are set and read 00 otherwise. For tag 1001 (coefficient), the byte passes through unchanged, zero included.
- R8: For tag 0001 (macroblock number, bits 5:0), the value is the number minus the previous macroblock number. A group record (tag 0000) resets that previous number to 0.
- R9: For tag 0100 (horizontal vector) and tag 0101 (vertical vector), each a 5-bit two's-complement field, the value is the current vector minus the predictor. The difference is wrapped modulo 32 into -16..+15 and sign-extended to 8 bits.
- R10: The predictor is zero when any of these holds for the current macroblock: its number is 1, 12 or 23, its address increment differs from 1, or the previous macroblock was not motion compensated. Otherwise the predictor is the previous macroblock's vector.
- R11: In a macroblock that is not motion compensated, both vector records carry the value 0. The vector stored for prediction is then also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_i | input | 1 | Transfer strobe from the source coder |
| tag_i | input | 4 | Type tag of the byte on `data_i` |
| data_i | input | 8 | Data byte |
| rec_valid_o | output | 1 | One-clock pulse, record present |
| rec_kind_o | output | 4 | Record kind, equal to the transfer tag |
| rec_val_o | output | 8 | Decoded or differential value |

## Verification
On every cycle, the embedded assertions check four things. Records appear only two clocks after a rising strobe that came with a valid tag. Control values never carry bits 7 or 4. Vector values always lie inside the sign-extended -16..+15 range. The address and vector history registers clear on a group record and on a macroblock that is not motion compensated. Only the bench's scenarios can show that the arithmetic is right. They cover increments across gaps and group changes, wrap-around in both directions, predictor clearing at rows 1, 12 and 23, a long-held strobe, and the absence of records for wait and unused tags.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
   localparam int BYTE_W = 8;
   localparam int TAG_W  = 4;

   typedef enum logic [TAG_W-1:0] {
      TAG_GOB   = 4'h0,
      TAG_MBN   = 4'h1,
      TAG_CTRL  = 4'h2,
      TAG_QUANT = 4'h3,
      TAG_HMV   = 4'h4,
      TAG_VMV   = 4'h5,
      TAG_CBP   = 4'h6,
      TAG_SUB   = 4'h7,
      TAG_RUN   = 4'h8,
      TAG_COEF  = 4'h9,
      TAG_WAIT  = 4'hF
   } tag_e;

   localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'b0110_1111;
   localparam logic [BYTE_W-1:0] CBP_KEEP  = 8'b0111_1110;
   localparam int CTRL_MC_BIT = 3;

   function automatic logic is_row_start(input logic [7:0] mb);
      return (mb == 8'd1) || (mb == 8'd12) || (mb == 8'd23);
   endfunction
endpackage

// File: rtl/mbd_strobe_capture.sv
module mbd_strobe_capture
   import mbd_pkg::*;
#(
   parameter int DW = BYTE_W,
   parameter int TW = TAG_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strb_i,
   input  logic [TW-1:0] tag_i,
   input  logic [DW-1:0] data_i,
   output logic          cap_vld_o,
   output logic [TW-1:0] cap_tag_o,
   output logic [DW-1:0] cap_data_o
);
   logic strb_q;
   logic rise;

   assign rise = strb_i & ~strb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strb_q     <= 1'b0;
         cap_vld_o  <= 1'b0;
         cap_tag_o  <= '0;
         cap_data_o <= '0;
      end else begin
         strb_q    <= strb_i;
         cap_vld_o <= rise;
         if (rise) begin
            cap_tag_o  <= tag_i;
            cap_data_o <= data_i;
         end
      end
   end

   // R2
   single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld_o |-> $past(strb_i) && !$past(strb_q));
endmodule

// File: rtl/mbd_addr_diff.sv
module mbd_addr_diff #(
   parameter int MBN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_gob_i,
   input  logic             load_mb_i,
   input  logic [MBN_W-1:0] mb_i,
   output logic [MBN_W:0]   diff_o
);
   logic [MBN_W-1:0] prev_mb;

   assign diff_o = {1'b0, mb_i} - {1'b0, prev_mb};

   always_ff @(posedge clk) begin
      if (!rst_n)          prev_mb <= '0;
      else if (load_gob_i) prev_mb <= '0;
      else if (load_mb_i)  prev_mb <= mb_i;
   end

   // R8
   gob_clears_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_gob_i |=> (prev_mb == '0));
endmodule

// File: rtl/mbd_mv_lane.sv
module mbd_mv_lane #(
   parameter int MV_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            mc_i,
   input  logic            pred_zero_i,
   input  logic [MV_W-1:0] vec_i,
   output logic [MV_W-1:0] diff_o
);
   logic [MV_W-1:0] prev_vec;
   logic [MV_W-1:0] pred;

   assign pred   = pred_zero_i ? '0 : prev_vec;
   // modulo 2^MV_W subtraction wraps into the signed range
   assign diff_o = mc_i ? (vec_i - pred) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)      prev_vec <= '0;
      else if (load_i) prev_vec <= mc_i ? vec_i : '0;
   end

   // R11
   no_mc_zero_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !mc_i) |=> (prev_vec == '0));
endmodule

// File: rtl/mb_field_decoder.sv
module mb_field_decoder
   import mbd_pkg::*;
#(
   parameter int GOB_W   = 4,
   parameter int MBN_W   = 6,
   parameter int QUANT_W = 5,
   parameter int SUB_W   = 3,
   parameter int MV_W    = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strb_i,
   input  logic [3:0]  tag_i,
   input  logic [7:0]  data_i,
   output logic        rec_valid_o,
   output logic [3:0]  rec_kind_o,
   output logic [7:0]  rec_val_o
);
   localparam int OUT_W = BYTE_W;
   localparam int NLANE = 2;

   if (MV_W >= OUT_W || MBN_W >= OUT_W || GOB_W >= OUT_W ||
       QUANT_W >= OUT_W || SUB_W >= OUT_W || MBN_W > 6) begin : g_bad_cfg
      $error("mb_field_decoder: field width does not fit the record");
   end

   logic              cap_vld;
   logic [TAG_W-1:0]  cap_tag;
   logic [BYTE_W-1:0] cap_data;

   mbd_strobe_capture #(.DW(BYTE_W), .TW(TAG_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .tag_i(tag_i), .data_i(data_i),
      .cap_vld_o(cap_vld), .cap_tag_o(cap_tag), .cap_data_o(cap_data)
   );

   logic ld_gob, ld_mb, ld_ctrl;
   assign ld_gob  = cap_vld && (cap_tag == TAG_GOB);
   assign ld_mb   = cap_vld && (cap_tag == TAG_MBN);
   assign ld_ctrl = cap_vld && (cap_tag == TAG_CTRL);

   logic [MBN_W:0] addr_diff;
   mbd_addr_diff #(.MBN_W(MBN_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_gob_i(ld_gob), .load_mb_i(ld_mb),
      .mb_i(cap_data[MBN_W-1:0]), .diff_o(addr_diff)
   );

   logic cur_mc, last_mc, pred_zero;
   logic [MV_W-1:0] mv_diff [NLANE];

   for (genvar a = 0; a < NLANE; a++) begin : g_lane
      localparam tag_e LANE_TAG = (a == 0) ? TAG_HMV : TAG_VMV;
      mbd_mv_lane #(.MV_W(MV_W)) u_lane (
         .clk(clk), .rst_n(rst_n),
         .load_i(cap_vld && (cap_tag == LANE_TAG)),
         .mc_i(cur_mc), .pred_zero_i(pred_zero),
         .vec_i(cap_data[MV_W-1:0]), .diff_o(mv_diff[a])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_mc    <= 1'b0;
         last_mc   <= 1'b0;
         pred_zero <= 1'b1;
      end else begin
         if (ld_ctrl) cur_mc <= cap_data[CTRL_MC_BIT];
         if (ld_mb)
            pred_zero <= is_row_start({{(8-MBN_W){1'b0}}, cap_data[MBN_W-1:0]}) ||
                         (addr_diff != {{MBN_W{1'b0}}, 1'b1}) || !last_mc;
         if (cap_vld && (cap_tag == TAG_VMV)) last_mc <= cur_mc;
      end
   end

   logic              val_ok;
   logic [OUT_W-1:0]  val_nx;
   logic              run_end;

   assign run_end = &cap_data[7:6];

   always_comb begin
      val_ok = 1'b1;
      val_nx = '0;
      case (cap_tag)
         TAG_GOB:   val_nx = {{(OUT_W-GOB_W){1'b0}}, cap_data[GOB_W-1:0]};
         TAG_MBN:   val_nx = {{(OUT_W-MBN_W-1){addr_diff[MBN_W]}}, addr_diff};
         TAG_CTRL:  val_nx = cap_data & CTRL_KEEP;
         TAG_QUANT: val_nx = {{(OUT_W-QUANT_W){1'b0}}, cap_data[QUANT_W-1:0]};
         TAG_HMV:   val_nx = {{(OUT_W-MV_W){mv_diff[0][MV_W-1]}}, mv_diff[0]};
         TAG_VMV:   val_nx = {{(OUT_W-MV_W){mv_diff[1][MV_W-1]}}, mv_diff[1]};
         TAG_CBP:   val_nx = cap_data & CBP_KEEP;
         TAG_SUB:   val_nx = {{(OUT_W-SUB_W){1'b0}}, cap_data[SUB_W-1:0]};
         TAG_RUN:   val_nx = {run_end, run_end, cap_data[5:0]};
         TAG_COEF:  val_nx = cap_data;
         default:   val_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_valid_o <= 1'b0;
         rec_kind_o  <= '0;
         rec_val_o   <= '0;
      end else begin
         rec_valid_o <= cap_vld && val_ok;
         if (cap_vld && val_ok) begin
            rec_kind_o <= cap_tag;
            rec_val_o  <= val_nx;
         end
      end
   end

   // R2
   rec_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> $past(strb_i, 2) && !$past(strb_i, 3));
   // R3
   rec_tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> ($past(tag_i, 2) <= 4'd9) && (rec_kind_o == $past(tag_i, 2)));
   // R4
   ctrl_unused_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && rec_kind_o == TAG_CTRL) |-> !rec_val_o[7] && !rec_val_o[4]);
   // R9
   mv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && (rec_kind_o == TAG_HMV || rec_kind_o == TAG_VMV))
         |-> (rec_val_o[7:4] == 4'h0 || rec_val_o[7:4] == 4'hF));
endmodule

// File: tb/mb_field_decoder_bench.sv
module mb_field_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strb_i = 1'b0;
   logic [3:0] tag_i = 4'hF;
   logic [7:0] data_i = 8'h00;
   logic       rec_valid_o;
   logic [3:0] rec_kind_o;
   logic [7:0] rec_val_o;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [3:0] q_kind [$];
   logic [7:0] q_val  [$];
   int         q_cyc  [$];
   string      q_req  [$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mb_field_decoder u_mb_field_decoder (
      .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .tag_i(tag_i), .data_i(data_i),
      .rec_valid_o(rec_valid_o), .rec_kind_o(rec_kind_o), .rec_val_o(rec_val_o)
   );

   // driver: one transfer, expected record pushed when present
   task automatic xfer(input logic [3:0] t, input logic [7:0] d, input int hold,
                       input bit present, input logic [7:0] ev, input string req);
      @(negedge clk);
      tag_i = t; data_i = d;
      @(negedge clk);
      strb_i = 1'b1;
      if (present) begin
         q_kind.push_back(t); q_val.push_back(ev);
         q_cyc.push_back(cyc + 2); q_req.push_back(req);
      end
      repeat (hold) @(negedge clk);
      strb_i = 1'b0;
      @(negedge clk);
      tag_i = 4'hF;
   endtask

   task automatic rec(input logic [3:0] t, input logic [7:0] d,
                      input logic [7:0] ev, input string req);
      xfer(t, d, 1, 1'b1, ev, req);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rec_valid_o && !done) begin
         tests++;
         if (q_kind.size() == 0) begin
            fails++;
            $display("FAIL R3 unexpected record kind=%h val=%h expected none",
                     rec_kind_o, rec_val_o);
         end else begin
            logic [3:0] ek; logic [7:0] ev; int ec; string er;
            ek = q_kind.pop_front(); ev = q_val.pop_front();
            ec = q_cyc.pop_front();  er = q_req.pop_front();
            if (rec_kind_o !== ek || rec_val_o !== ev || cyc != ec) begin
               fails++;
               $display("FAIL %s kind=%h val=%h cyc=%0d expected kind=%h val=%h cyc=%0d",
                        er, rec_kind_o, rec_val_o, cyc, ek, ev, ec);
            end
         end
      end
   end

   task automatic finish_run;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired with %0d records pending", q_kind.size());
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      tests++;
      if (rec_valid_o !== 1'b0) begin fails++;
         $display("FAIL R1 rec_valid_o=%b expected 0 in reset", rec_valid_o); end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      tests++;
      if (rec_valid_o !== 1'b0) begin fails++;
         $display("FAIL R1 rec_valid_o=%b expected 0 after reset", rec_valid_o); end

      // macroblock 1 of group 3
      rec(4'h2, 8'h98, 8'h08, "R4 control mask");
      rec(4'h0, 8'hF3, 8'h03, "R6 group field");
      rec(4'h1, 8'h01, 8'h01, "R8 first address");
      rec(4'h6, 8'hFF, 8'h7E, "R5 cbp mask");
      rec(4'h3, 8'hEA, 8'h0A, "R6 quant field");
      rec(4'h4, 8'h05, 8'h05, "R10 row start horiz");
      rec(4'h5, 8'h1D, 8'hFD, "R10 row start vert");
      rec(4'h7, 8'hFB, 8'h03, "R6 sub-block field");
      rec(4'h8, 8'h05, 8'h05, "R7 run");
      rec(4'h9, 8'h80, 8'h80, "R7 coefficient");
      rec(4'h8, 8'h85, 8'h05, "R7 run single high bit");
      rec(4'h9, 8'h11, 8'h11, "R7 coefficient");
      rec(4'h8, 8'hC0, 8'hC0, "R7 end marker");
      rec(4'h9, 8'h00, 8'h00, "R7 zero coefficient");
      // macroblock 2: predicted, positive wrap
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h02, 8'h01, "R8 increment");
      rec(4'h4, 8'h1F, 8'hFA, "R9 horiz diff");
      rec(4'h5, 8'h0F, 8'hF2, "R9 vert wrap down");
      // macroblock 3: no motion compensation
      rec(4'h2, 8'h00, 8'h00, "R4 control");
      rec(4'h1, 8'h03, 8'h01, "R8 increment");
      rec(4'h4, 8'h07, 8'h00, "R11 horiz zero");
      rec(4'h5, 8'h04, 8'h00, "R11 vert zero");
      // macroblock 4: predictor cleared by previous non-mc
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h04, 8'h01, "R8 increment");
      rec(4'h4, 8'h0A, 8'h0A, "R10 after non-mc horiz");
      rec(4'h5, 8'h11, 8'hF1, "R10 after non-mc vert");
      // macroblock 6: gap
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h06, 8'h02, "R8 gap");
      rec(4'h4, 8'h03, 8'h03, "R10 gap horiz");
      rec(4'h5, 8'h12, 8'hF2, "R10 gap vert");
      // macroblock 11, then 12 (row start), 13, 14
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h0B, 8'h05, "R8 gap");
      rec(4'h4, 8'h01, 8'h01, "R10 gap horiz");
      rec(4'h5, 8'h01, 8'h01, "R10 gap vert");
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h0C, 8'h01, "R8 increment");
      rec(4'h4, 8'h02, 8'h02, "R10 mb12 horiz");
      rec(4'h5, 8'h1E, 8'hFE, "R10 mb12 vert");
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h0D, 8'h01, "R8 increment");
      rec(4'h4, 8'h0F, 8'h0D, "R9 horiz diff");
      rec(4'h5, 8'h11, 8'hF3, "R9 vert diff");
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h0E, 8'h01, "R8 increment");
      rec(4'h4, 8'h11, 8'h02, "R9 horiz wrap up");
      rec(4'h5, 8'h0F, 8'hFE, "R9 vert wrap down");
      // new group resets address history
      rec(4'h0, 8'h05, 8'h05, "R6 group field");
      rec(4'h2, 8'h08, 8'h08, "R4 control");
      rec(4'h1, 8'h03, 8'h03, "R8 group reset");
      // wait and unused tags with strobe: no record
      xfer(4'hF, 8'h55, 1, 1'b0, 8'h00, "R3");
      xfer(4'hA, 8'h55, 1, 1'b0, 8'h00, "R3");
      xfer(4'hE, 8'h55, 1, 1'b0, 8'h00, "R3");
      // long strobe: single record
      xfer(4'h3, 8'h1F, 6, 1'b1, 8'h1F, "R2 long strobe");
      rec(4'h7, 8'h06, 8'h06, "R2 after long strobe");

      repeat (6) @(negedge clk);
      tests++;
      if (q_kind.size() != 0) begin fails++;
         $display("FAIL R2 %0d records missing expected 0", q_kind.size()); end
      finish_run();
   end
endmodule